// File: doc/BRIEF.md
# Sixty-Four Source Vectored Interrupt Router

This block collects 64 interrupt request lines and forwards each to one of 256 upstream interrupt outputs. The output a source drives is picked by an 8-bit vector that software programs per source. Each source is sensed either on its rising edge or by its level. The block keeps three 64-bit state vectors: pending, last-sampled input and in-service. An output is raised when a pending, unmasked source is accepted into service. It is lowered when that service ends.

Software reaches the 64-bit registers through a 32-bit bus, as a low word at an aligned offset and a high word at offset+4. It reaches the vector table through a separate byte-wide bus. The registers are mask, edge select, write-one-to-clear, status, a stored-only polarity word and two identification words. Each cycle the block first applies input changes and then the bus write, so a write overrides input effects on the bits it touches.

Top module: `irq_vec_router`

## Requirements
- R1: After reset every register, every vector entry, every bit of irq_out and both read-data outputs are zero.
- R2: The edge-select register sits at byte offsets 0x10 (sources 31:0) and 0x14 (sources 63:32). A 1 bit makes that source edge-sensed and a 0 bit makes it level-sensed.
- R3: An edge source becomes pending when its input is high after being sampled low on the previous clock. A falling input never clears pending. An input held high produces no further event.
- R4: For a level source, the pending bit follows the input as sampled on each clock.
- R5: When inputs rise, the block considers the bits that are rising, pending and unmasked, and takes the lowest-numbered one. It sets that source's in-service bit, and on the next clock irq_out[vector] is 1. Other rising sources are not accepted in that cycle.
- R6: When inputs fall, the block considers the bits that are falling, in service and no longer pending, and takes the lowest-numbered one. It clears that in-service bit and drives irq_out[vector] to 0.
- R7: The clear register is at 0x18/0x1C. A write clears pending and in-service for the written bits that are edge-sensed, and drives low the output of the lowest such bit that was in service. Level-sensed bits in the write have no effect. The register reads as zero.
- R8: The mask register is at 0x08/0x0C, where 1 means masked. Bits that a write unmasks go through the R5 acceptance rule. Bits that a write masks go through the R6 release rule, so a source that is still pending keeps its output high.
- R9: Every 64-bit register is read and written in 32-bit halves, and a write replaces only the addressed half. Read data appears on the clock after the read strobe and holds until the next read. The polarity word at 0x28/0x2C is only stored and read back.
- R10: Offset 0x00 reads CHIP_ID. Offset 0x04 reads the source count minus one (63) in bits 31:16 and VERSION in bits 15:0.
- R11: The status register at 0x20/0x24 reads as in-service AND NOT mask for the addressed half. A write replaces that half of the in-service vector.
- R12: vec_addr 0..63 selects one vector byte. Higher vec_addr values read zero, and writes to them change nothing. Register offsets 0x30 to 0x3C read zero and ignore writes.
- R13: When an input event and a register write happen in the same cycle, the input event is evaluated first. The write then applies on top, so its effect wins on the written bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 64 | Source interrupt lines |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 8 | Register byte offset (word aligned) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered register read data |
| vec_wr | input | 1 | Vector table write strobe |
| vec_rd | input | 1 | Vector table read strobe |
| vec_addr | input | 8 | Vector table index |
| vec_wdata | input | 8 | Vector write data |
| vec_rdata | output | 8 | Registered vector read data |
| irq_out | output | 256 | Upstream interrupt outputs |

## Verification
A corrupted pending or in-service bit shows up on irq_out one clock after the next edge of that source. An output either stays high after release or never rises. The status read exposes the same error on the next read. A wrong priority pick shows up in the same cycle as a raised output whose index belongs to a higher-numbered source's vector. A mis-decoded half-word write shows up on the next read of the untouched half. The bench checks both the outputs and these reads one clock after each stimulus.

// File: rtl/irq_vec_router.sv
`timescale 1ns/1ps
module irq_vec_router #(
  parameter logic [15:0] VERSION = 16'h0001,
  parameter logic [31:0] CHIP_ID = 32'h4952_5130
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [63:0]  irq_in,
  input  logic         reg_wr,
  input  logic         reg_rd,
  input  logic [7:0]   reg_addr,
  input  logic [31:0]  reg_wdata,
  output logic [31:0]  reg_rdata,
  input  logic         vec_wr,
  input  logic         vec_rd,
  input  logic [7:0]   vec_addr,
  input  logic [7:0]   vec_wdata,
  output logic [7:0]   vec_rdata,
  output logic [255:0] irq_out
);
  localparam int NSRC = 64;
  localparam logic [15:0] SRC_MAX = 16'(NSRC - 1);

  logic [63:0] mask, edge_sel, pol, pend, last, isr;
  logic [7:0]  vec_tab [NSRC];

  logic [63:0] mask_n, edge_n, pol_n, pend_n, isr_n;
  logic [63:0] up, dn, clr;
  logic [255:0] out_n;
  logic [6:0]  pa, pb, pc, pd;

  function automatic logic [6:0] pick_low(input logic [63:0] v);
    pick_low = 7'd0;
    for (int i = NSRC - 1; i >= 0; i--)
      if (v[i]) pick_low = {1'b1, 6'(i)};
  endfunction

  function automatic logic [63:0] put_half(input logic [63:0] o, input logic [31:0] d, input logic h);
    return h ? {d, o[31:0]} : {o[63:32], d};
  endfunction

  function automatic logic [31:0] get_half(input logic [63:0] v, input logic h);
    return h ? v[63:32] : v[31:0];
  endfunction

  wire        hit  = (reg_addr[7:6] == 2'b00) && (reg_addr[1:0] == 2'b00);
  wire [2:0]  wsel = reg_addr[5:3];
  wire        hi   = reg_addr[2];
  wire        wr_ok = reg_wr && hit;
  wire [63:0] wide = hi ? {reg_wdata, 32'd0} : {32'd0, reg_wdata};
  wire [63:0] rise = irq_in & ~last;
  wire [63:0] fall = ~irq_in & last;
  wire        vec_ok = (vec_addr[7:6] == 2'b00);

  always_comb begin
    mask_n = mask;
    edge_n = edge_sel;
    pol_n  = pol;
    out_n  = irq_out;
    up = '0;
    dn = '0;
    clr = '0;
    pend_n = (edge_sel & (pend | rise)) | (~edge_sel & irq_in);
    isr_n  = isr;

    pa = pick_low(rise & pend_n & ~mask);
    if (pa[6]) begin
      isr_n[pa[5:0]] = 1'b1;
      out_n[vec_tab[pa[5:0]]] = 1'b1;
    end
    pb = pick_low(fall & isr_n & ~pend_n);
    if (pb[6]) begin
      isr_n[pb[5:0]] = 1'b0;
      out_n[vec_tab[pb[5:0]]] = 1'b0;
    end

    if (wr_ok) begin
      case (wsel)
        3'd1: begin
          mask_n = put_half(mask, reg_wdata, hi);
          up = mask & ~mask_n;
          dn = ~mask & mask_n;
        end
        3'd2: edge_n = put_half(edge_sel, reg_wdata, hi);
        3'd3: begin
          clr = wide & edge_sel;
          pend_n = pend_n & ~clr;
          dn = clr;
        end
        3'd4: isr_n = put_half(isr_n, reg_wdata, hi);
        3'd5: pol_n = put_half(pol, reg_wdata, hi);
        default: ;
      endcase
    end

    pc = pick_low(up & pend_n & ~mask_n);
    if (pc[6]) begin
      isr_n[pc[5:0]] = 1'b1;
      out_n[vec_tab[pc[5:0]]] = 1'b1;
    end
    pd = pick_low(dn & isr_n & ~pend_n);
    if (pd[6]) begin
      isr_n[pd[5:0]] = 1'b0;
      out_n[vec_tab[pd[5:0]]] = 1'b0;
    end
    isr_n = isr_n & ~clr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask <= '0;
      edge_sel <= '0;
      pol <= '0;
      pend <= '0;
      last <= '0;
      isr <= '0;
      irq_out <= '0;
      reg_rdata <= '0;
      vec_rdata <= '0;
      for (int i = 0; i < NSRC; i++) vec_tab[i] <= '0;
    end else begin
      mask <= mask_n;
      edge_sel <= edge_n;
      pol <= pol_n;
      pend <= pend_n;
      last <= irq_in;
      isr <= isr_n;
      irq_out <= out_n;
      if (vec_wr && vec_ok) vec_tab[vec_addr[5:0]] <= vec_wdata;
      if (vec_rd) vec_rdata <= vec_ok ? vec_tab[vec_addr[5:0]] : 8'd0;
      if (reg_rd) begin
        if (!hit) reg_rdata <= '0;
        else case (wsel)
          3'd0: reg_rdata <= hi ? {SRC_MAX, VERSION} : CHIP_ID;
          3'd1: reg_rdata <= get_half(mask, hi);
          3'd2: reg_rdata <= get_half(edge_sel, hi);
          3'd4: reg_rdata <= get_half(isr & ~mask, hi);
          3'd5: reg_rdata <= get_half(pol, hi);
          default: reg_rdata <= '0;
        endcase
      end
    end
  end
endmodule

module irq_vec_router_chk #(
  parameter logic [15:0] VERSION = 16'h0001
) (
  input logic         clk,
  input logic         rst_n,
  input logic [63:0]  irq_in,
  input logic         reg_wr,
  input logic         reg_rd,
  input logic [7:0]   reg_addr,
  input logic [31:0]  reg_rdata,
  input logic         vec_rd,
  input logic [7:0]   vec_addr,
  input logic [7:0]   vec_rdata,
  input logic [255:0] irq_out,
  input logic [63:0]  pend,
  input logic [63:0]  edge_sel,
  input logic [63:0]  last_in
);
  wire clr_hit = reg_wr && (reg_addr == 8'h18 || reg_addr == 8'h1C);

  a_r4_level_follows: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> ((pend & ~$past(edge_sel)) == ($past(irq_in) & ~$past(edge_sel))));

  a_r3_edge_keeps_pending: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && !clr_hit) |=> ((($past(pend) & $past(edge_sel)) & ~pend) == 64'd0));

  a_r5_single_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && !reg_wr) |=> ($countones(irq_out & ~$past(irq_out)) <= 1));

  a_r6_quiet_outputs: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && !reg_wr && irq_in == last_in) |=> $stable(irq_out));

  a_r12_vec_oob_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && vec_rd && vec_addr[7:6] != 2'b00) |=> (vec_rdata == 8'd0));

  a_r10_id_word: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && reg_rd && reg_addr == 8'h04) |=> (reg_rdata == {16'd63, VERSION}));
endmodule

bind irq_vec_router irq_vec_router_chk #(.VERSION(VERSION)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .reg_wr(reg_wr), .reg_rd(reg_rd),
  .reg_addr(reg_addr), .reg_rdata(reg_rdata), .vec_rd(vec_rd), .vec_addr(vec_addr),
  .vec_rdata(vec_rdata), .irq_out(irq_out), .pend(pend), .edge_sel(edge_sel),
  .last_in(last)
);

// File: tb/irq_vec_router_test.sv
`timescale 1ns/1ps
module irq_vec_router_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [63:0] irq_in = '0;
  logic reg_wr = 0, reg_rd = 0, vec_wr = 0, vec_rd = 0;
  logic [7:0] reg_addr = 0, vec_addr = 0, vec_wdata = 0;
  logic [31:0] reg_wdata = 0;
  logic [31:0] reg_rdata;
  logic [7:0] vec_rdata;
  logic [255:0] irq_out;

  localparam logic [31:0] ID0 = 32'h4952_5130;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct { bit is_vec; logic [31:0] exp; string tag; } item_t;
  item_t sb[$];
  logic rd_seen = 0;

  irq_vec_router uut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .vec_wr(vec_wr), .vec_rd(vec_rd), .vec_addr(vec_addr), .vec_wdata(vec_wdata),
    .vec_rdata(vec_rdata), .irq_out(irq_out)
  );

  always #2.5 clk = ~clk;

  always @(posedge clk) rd_seen <= reg_rd | vec_rd;

  always @(negedge clk) begin
    if (rd_seen) begin
      if (sb.size() == 0) begin
        checks++; errors++;
        $display("FAIL scoreboard empty on read return");
      end else begin
        item_t it;
        logic [31:0] act;
        it = sb.pop_front();
        act = it.is_vec ? {24'd0, vec_rdata} : reg_rdata;
        checks++;
        if (act !== it.exp) begin
          errors++;
          $display("FAIL %s actual %h expected %h", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic reg_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic reg_read(input logic [7:0] a, input logic [31:0] e, input string tag);
    item_t it;
    @(negedge clk); reg_rd = 1; reg_addr = a;
    it.is_vec = 0; it.exp = e; it.tag = tag; sb.push_back(it);
    @(negedge clk); reg_rd = 0;
  endtask

  task automatic vec_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); vec_wr = 1; vec_addr = a; vec_wdata = d;
    @(negedge clk); vec_wr = 0;
  endtask

  task automatic vec_read(input logic [7:0] a, input logic [7:0] e, input string tag);
    item_t it;
    @(negedge clk); vec_rd = 1; vec_addr = a;
    it.is_vec = 1; it.exp = {24'd0, e}; it.tag = tag; sb.push_back(it);
    @(negedge clk); vec_rd = 0;
  endtask

  task automatic set_in(input int i, input logic v);
    @(negedge clk); irq_in[i] = v;
    @(negedge clk);
  endtask

  task automatic chk_out(input int idx, input logic e, input string tag);
    checks++;
    if (irq_out[idx] !== e) begin
      errors++;
      $display("FAIL %s irq_out[%0d] actual %b expected %b", tag, idx, irq_out[idx], e);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    checks++;
    if (irq_out !== '0) begin
      errors++;
      $display("FAIL R1 irq_out actual %h expected 0", irq_out);
    end
    reg_read(8'h08, 32'h0, "R1 mask after reset");
    vec_read(8'd0, 8'h00, "R1 vector after reset");
    reg_read(8'h00, ID0, "R10 id word 0");
    reg_read(8'h04, 32'h003F_0001, "R10 id word 1");

    vec_write(8'd3, 8'h10);
    vec_write(8'd7, 8'h22);
    vec_write(8'd40, 8'hC5);
    vec_write(8'd1, 8'h30);
    vec_write(8'd2, 8'h31);
    vec_write(8'd70, 8'h55);
    vec_read(8'd70, 8'h00, "R12 vector out of range read");
    vec_read(8'd6, 8'h00, "R12 out of range write ignored");
    vec_read(8'd40, 8'hC5, "R12 vector readback");

    reg_write(8'h10, 32'h80);
    reg_write(8'h14, 32'h100);
    reg_read(8'h10, 32'h80, "R2 edge low half");
    reg_read(8'h14, 32'h100, "R2 edge high half");

    set_in(3, 1);
    chk_out(8'h10, 1, "R4 R5 level source raises output");
    reg_read(8'h20, 32'h8, "R11 status low");
    set_in(3, 0);
    chk_out(8'h10, 0, "R6 level source release");
    reg_read(8'h20, 32'h0, "R4 status after release");

    set_in(3, 1);
    set_in(7, 1);
    set_in(7, 0);
    chk_out(8'h22, 1, "R3 edge output survives falling input");
    reg_read(8'h20, 32'h88, "R11 status two sources");
    reg_write(8'h18, 32'h88);
    chk_out(8'h22, 0, "R7 clear lowers edge output");
    chk_out(8'h10, 1, "R7 level bit in clear ignored");
    reg_read(8'h20, 32'h08, "R7 status after clear");
    reg_read(8'h18, 32'h0, "R7 clear reads zero");
    set_in(3, 0);
    chk_out(8'h10, 0, "R6 level release");

    set_in(7, 1);
    chk_out(8'h22, 1, "R3 edge rise");
    reg_write(8'h18, 32'h80);
    @(negedge clk);
    chk_out(8'h22, 0, "R3 held high gives no new event");
    set_in(7, 0);
    chk_out(8'h22, 0, "R3 fall after clear");

    set_in(40, 1);
    set_in(40, 0);
    chk_out(8'hC5, 1, "R3 high source edge");
    reg_read(8'h24, 32'h100, "R11 status high");
    reg_write(8'h1C, 32'h100);
    chk_out(8'hC5, 0, "R7 clear high half");
    reg_read(8'h24, 32'h0, "R7 status high after clear");

    reg_write(8'h08, 32'h8);
    set_in(3, 1);
    chk_out(8'h10, 0, "R5 masked source not accepted");
    reg_read(8'h20, 32'h0, "R11 masked status");
    reg_write(8'h08, 32'h0);
    chk_out(8'h10, 1, "R8 unmask accepts pending source");
    reg_write(8'h08, 32'h8);
    chk_out(8'h10, 1, "R8 mask keeps output while pending");
    reg_read(8'h20, 32'h0, "R11 status hides masked bit");
    reg_write(8'h08, 32'h0);
    set_in(3, 0);
    chk_out(8'h10, 0, "R6 release after mask cycle");

    @(negedge clk); irq_in[1] = 1; irq_in[2] = 1;
    @(negedge clk);
    chk_out(8'h30, 1, "R5 lowest rising source accepted");
    chk_out(8'h31, 0, "R5 higher rising source not accepted");
    reg_read(8'h20, 32'h2, "R5 only lowest in service");
    @(negedge clk); irq_in[1] = 0; irq_in[2] = 0;
    @(negedge clk);
    chk_out(8'h30, 0, "R6 lowest released");

    @(negedge clk); irq_in[7] = 1; reg_wr = 1; reg_addr = 8'h18; reg_wdata = 32'h80;
    @(negedge clk); reg_wr = 0;
    chk_out(8'h22, 0, "R13 clear wins over same-cycle rise");
    reg_read(8'h20, 32'h0, "R13 status after same-cycle clear");
    set_in(7, 0);

    @(negedge clk); irq_in[3] = 1; reg_wr = 1; reg_addr = 8'h08; reg_wdata = 32'h8;
    @(negedge clk); reg_wr = 0;
    chk_out(8'h10, 1, "R13 input evaluated before mask write");
    reg_write(8'h08, 32'h0);
    set_in(3, 0);
    chk_out(8'h10, 0, "R6 final release");

    reg_write(8'h08, 32'h5);
    reg_write(8'h0C, 32'hF0);
    reg_read(8'h08, 32'h5, "R9 low half kept");
    reg_read(8'h0C, 32'hF0, "R9 high half written");
    reg_write(8'h28, 32'hA5A5);
    reg_read(8'h28, 32'hA5A5, "R9 polarity low");
    reg_read(8'h2C, 32'h0, "R9 polarity high untouched");

    reg_write(8'h24, 32'h1234);
    reg_read(8'h24, 32'h1204, "R11 status write and mask view");

    reg_write(8'h30, 32'hFFFF_FFFF);
    reg_read(8'h30, 32'h0, "R12 reserved word reads zero");
    reg_read(8'h34, 32'h0, "R12 reserved word high");

    repeat (3) @(negedge clk);
    if (sb.size() != 0) begin
      checks++; errors++;
      $display("FAIL scoreboard has %0d unmatched items expected 0", sb.size());
    end
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule